// File: doc/BRIEF.md
# Egress Timestamp Queue with Locking Read Buffer

This block collects transmit timestamps from the egress path and hands them to software one at a time. Every timestamp arrives on a one-cycle push strobe. It carries an 8-bit PTP domain number, 30 bits of nanoseconds and 5 bits of seconds. Accepted timestamps wait in a 4-entry first-in first-out queue. The oldest entry is shown through a holding buffer of four read-only 16-bit words on a small register bus. The bus has address, write data, write enable, read enable and a registered read data port.

The holding buffer is a two-state machine. In `HOLD_OPEN` the buffer holds no valid timestamp. In `HOLD_LOCKED` the buffer holds a valid timestamp and keeps it. These are the transitions:

- `LOAD` (`HOLD_OPEN` to `HOLD_LOCKED`): the oldest queue entry is copied into the buffer.
- `RELEASE` (`HOLD_LOCKED` to `HOLD_OPEN`): software writes any buffer word.
- `RELOAD` (`HOLD_LOCKED` to `HOLD_LOCKED`, legacy mode only): a ring-done command arrives while the queue has an entry.
- `DRAIN` (`HOLD_LOCKED` to `HOLD_OPEN`, legacy mode only): a ring-done command arrives while the queue is empty.

The `MODE` parameter selects how the block behaves:

- **Auto mode:** `LOAD` happens by itself whenever the buffer is open and the queue has an entry. The interrupt is a sticky status bit that software clears.
- **Legacy mode:** an entry moves only on a software command. The interrupt simply follows "queue not empty".

Top module: `egts_hold_fifo`

## Requirements
- R1: After reset the queue is empty, the buffer is open with its valid flag (word 0 bit 0) at 0, all held fields read 0, the overflow count (address 6) reads 0 and `irq` is low.
- R2: In auto mode, a pushed timestamp loads into an open buffer by itself, and is visible to a read issued two cycles after the push. The buffer words are laid out as follows:
  - word 0 (address 0): domain in bits 15:8, seconds 1:0 in bits 2:1, valid flag in bit 0.
  - word 1 (address 1): nanoseconds 15:0.
  - word 2 (address 2): nanoseconds 29:16 in bits 13:0.
  - word 3 (address 3): seconds 4:2 in bits 2:0.
- R3: While the buffer is locked, later pushes leave its contents unchanged. Bit 15 of word 3 reads 1 exactly when the queue holds at least one more entry.
- R4: A write of any data to any of addresses 0 to 3 clears the valid flag and unlocks the buffer. In auto mode the next-oldest entry then loads one cycle later, so entries come out in push order.
- R5: A write to address 3 with bit 0 set, while the valid flag is 0, loads the oldest queued entry at once (manual move). The same write while valid is 1 only releases the buffer.
- R6: In auto mode `irq` sets on every accepted push and stays set until software writes address 4 with bit 1 set. A write to address 4 with bit 1 clear leaves it set. Reading address 4 returns the status in bit 1.
- R7: In auto mode `irq` also sets when an automatic load leaves at least one entry still queued. A load that empties the queue does not set it.
- R8: In legacy mode nothing loads by itself. A write to address 5 with bit 0 set (ring done) copies the oldest entry into the buffer and sets the valid flag. If the queue is empty, the same write clears the valid flag.
- R9: In legacy mode `irq` is high exactly while the queue holds entries. A write to address 4 does not clear it.
- R10: A push that arrives while the queue already holds 4 entries is dropped. A dropped push adds 1 to an 8-bit overflow count at address 6, and the count saturates at 255.
- R11: `reg_rdata` shows the addressed word on the clock after `reg_re` is sampled high, and holds its value while `reg_re` is low.
- R12: A push and a buffer release in the same cycle both take effect, and the pushed entry loads next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ts_push | input | 1 | Push strobe for a new egress timestamp |
| ts_domain | input | 8 | PTP domain number of the pushed timestamp |
| ts_ns | input | 30 | Nanoseconds of the pushed timestamp |
| ts_sec | input | 5 | Seconds of the pushed timestamp |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 16 | Register write data |
| reg_we | input | 1 | Register write enable |
| reg_re | input | 1 | Register read enable |
| reg_rdata | output | 16 | Registered read data |
| irq | output | 1 | Egress timestamp interrupt |

## Verification
An auto-mode instance and a legacy-mode instance are driven separately.

The auto instance gets four kinds of stimulus:

- A single push into an empty queue. This separates self-loading from waiting for software.
- Bursts of pushes behind a locked buffer. These separate locking from overwriting.
- A push that coincides with a release. This shows whether both events are kept.
- A flood of pushes into a full queue. This exposes drop counting and saturation.

Reading the buffer in the same cycle as a release, and again one cycle later, separates the open window from the following load.

The legacy instance receives ring-done and manual-move writes with the queue full, empty and partly filled. This separates command-driven transfer from automatic transfer, and level interrupts from sticky ones.

// File: rtl/egts_pkg.sv
`timescale 1ns/1ps
package egts_pkg;
    localparam int DOM_W  = 8;
    localparam int NS_W   = 30;
    localparam int SEC_W  = 5;
    localparam int REG_W  = 16;
    localparam int ADDR_W = 3;

    typedef struct packed {
        logic [DOM_W-1:0] domain;
        logic [SEC_W-1:0] sec;
        logic [NS_W-1:0]  ns;
    } egts_entry_t;

    typedef enum logic {
        EGTS_AUTO   = 1'b0,
        EGTS_LEGACY = 1'b1
    } egts_mode_e;

    typedef enum logic {
        HOLD_OPEN   = 1'b0,
        HOLD_LOCKED = 1'b1
    } hold_state_e;

    // Word addresses on the register bus
    localparam logic [ADDR_W-1:0] A_WORD0 = 3'd0;
    localparam logic [ADDR_W-1:0] A_WORD1 = 3'd1;
    localparam logic [ADDR_W-1:0] A_WORD2 = 3'd2;
    localparam logic [ADDR_W-1:0] A_WORD3 = 3'd3;
    localparam logic [ADDR_W-1:0] A_IRQ   = 3'd4;
    localparam logic [ADDR_W-1:0] A_RING  = 3'd5;
    localparam logic [ADDR_W-1:0] A_OVF   = 3'd6;
endpackage

// File: rtl/egts_fifo.sv
`timescale 1ns/1ps
module egts_fifo
    import egts_pkg::*;
#(
    parameter int  DEPTH = 4,
    parameter int  OVF_W = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  egts_entry_t      push_data,
    input  logic             pop,
    output egts_entry_t      head,
    output logic             accepted,
    output logic [CNT_W-1:0] count,
    output logic [OVF_W-1:0] ovf_cnt
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    egts_entry_t      mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             full;

    assign full     = (count == CNT_W'(DEPTH));
    assign accepted = push && !full;
    assign head     = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (accepted) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            count   <= '0;
            ovf_cnt <= '0;
        end else begin
            if (accepted) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (pop)      rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            case ({accepted, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
            if (push && full && (ovf_cnt != {OVF_W{1'b1}}))
                ovf_cnt <= ovf_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/egts_hold_ctrl.sv
`timescale 1ns/1ps
module egts_hold_ctrl
    import egts_pkg::*;
#(
    parameter egts_mode_e MODE = EGTS_AUTO
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        fifo_nonempty,
    input  logic        win_we,
    input  logic        move_req,
    input  logic        ring_done,
    input  egts_entry_t head,
    output logic        load,
    output logic        valid,
    output egts_entry_t held
);
    hold_state_e state_q, state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= HOLD_OPEN;
        else        state_q <= state_d;
    end

    // Next state and load strobe
    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        unique case (state_q)
            HOLD_OPEN: begin
                if (fifo_nonempty &&
                    ((MODE == EGTS_AUTO) || move_req || ring_done)) begin
                    load    = 1'b1;          // LOAD
                    state_d = HOLD_LOCKED;
                end
            end
            HOLD_LOCKED: begin
                if (ring_done) begin
                    if (fifo_nonempty) load = 1'b1;        // RELOAD
                    else               state_d = HOLD_OPEN; // DRAIN
                end else if (win_we) begin
                    state_d = HOLD_OPEN;                    // RELEASE
                end
            end
            default: state_d = HOLD_OPEN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    held <= '0;
        else if (load) held <= head;
    end

    assign valid = (state_q == HOLD_LOCKED);
endmodule

// File: rtl/egts_irq.sv
`timescale 1ns/1ps
module egts_irq
    import egts_pkg::*;
#(
    parameter egts_mode_e MODE = EGTS_AUTO
) (
    input  logic clk,
    input  logic rst_n,
    input  logic accepted,
    input  logic load,
    input  logic pending_after,
    input  logic ack,
    input  logic fifo_nonempty,
    output logic irq
);
    generate
        if (MODE == EGTS_AUTO) begin : g_sticky
            logic status_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    status_q <= 1'b0;
                else if (accepted || (load && pending_after))
                    status_q <= 1'b1;
                else if (ack)
                    status_q <= 1'b0;
            end
            assign irq = status_q;
        end else begin : g_level
            assign irq = fifo_nonempty;
        end
    endgenerate
endmodule

// File: rtl/egts_hold_fifo.sv
`timescale 1ns/1ps
module egts_hold_fifo
    import egts_pkg::*;
#(
    parameter egts_mode_e MODE  = EGTS_AUTO,
    parameter int         DEPTH = 4,
    parameter int         OVF_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ts_push,
    input  logic [DOM_W-1:0]  ts_domain,
    input  logic [NS_W-1:0]   ts_ns,
    input  logic [SEC_W-1:0]  ts_sec,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    input  logic              reg_we,
    input  logic              reg_re,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              irq
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    egts_entry_t      push_entry, head_entry, held_entry;
    logic [CNT_W-1:0] fifo_count;
    logic [OVF_W-1:0] ovf_count;
    logic             accepted, load, hold_valid, fifo_nonempty, pending_after;
    logic             win_we, move_req, ring_done, irq_ack;
    logic [REG_W-1:0] rd_word;

    assign push_entry    = '{domain: ts_domain, sec: ts_sec, ns: ts_ns};
    assign fifo_nonempty = (fifo_count != '0);
    assign pending_after = (fifo_count > CNT_W'(1)) || accepted;

    // Register write decode
    assign win_we    = reg_we && (reg_addr <= A_WORD3);
    assign move_req  = reg_we && (reg_addr == A_WORD3) && reg_wdata[0];
    assign ring_done = (MODE == EGTS_LEGACY) && reg_we &&
                       (reg_addr == A_RING) && reg_wdata[0];
    assign irq_ack   = reg_we && (reg_addr == A_IRQ) && reg_wdata[1];

    egts_fifo #(.DEPTH(DEPTH), .OVF_W(OVF_W)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (ts_push),
        .push_data (push_entry),
        .pop       (load),
        .head      (head_entry),
        .accepted  (accepted),
        .count     (fifo_count),
        .ovf_cnt   (ovf_count)
    );

    egts_hold_ctrl #(.MODE(MODE)) u_hold (
        .clk           (clk),
        .rst_n         (rst_n),
        .fifo_nonempty (fifo_nonempty),
        .win_we        (win_we),
        .move_req      (move_req),
        .ring_done     (ring_done),
        .head          (head_entry),
        .load          (load),
        .valid         (hold_valid),
        .held          (held_entry)
    );

    egts_irq #(.MODE(MODE)) u_irq (
        .clk           (clk),
        .rst_n         (rst_n),
        .accepted      (accepted),
        .load          (load),
        .pending_after (pending_after),
        .ack           (irq_ack),
        .fifo_nonempty (fifo_nonempty),
        .irq           (irq)
    );

    // Read word selection
    always_comb begin
        case (reg_addr)
            A_WORD0: rd_word = {held_entry.domain, 5'b0, held_entry.sec[1:0], hold_valid};
            A_WORD1: rd_word = held_entry.ns[15:0];
            A_WORD2: rd_word = {2'b0, held_entry.ns[29:16]};
            A_WORD3: rd_word = {fifo_nonempty, 12'b0, held_entry.sec[4:2]};
            A_IRQ:   rd_word = {14'b0, irq, 1'b0};
            A_OVF:   rd_word = REG_W'(ovf_count);
            default: rd_word = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      reg_rdata <= '0;
        else if (reg_re) reg_rdata <= rd_word;
    end
endmodule

// File: rtl/egts_hold_fifo_chk.sv
`timescale 1ns/1ps
module egts_hold_fifo_chk
    import egts_pkg::*;
#(
    parameter egts_mode_e MODE  = EGTS_AUTO,
    parameter int         DEPTH = 4,
    parameter int         OVF_W = 8,
    localparam int        CNT_W = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ts_push,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [REG_W-1:0]  reg_wdata,
    input logic              reg_we,
    input logic              reg_re,
    input logic [REG_W-1:0]  reg_rdata,
    input logic              irq,
    input logic              hold_valid,
    input logic [CNT_W-1:0]  fifo_count,
    input egts_entry_t       held_entry,
    input logic [OVF_W-1:0]  ovf_count
);
    logic win_wr, ack_wr;
    assign win_wr = reg_we && !reg_addr[2];
    assign ack_wr = reg_we && (reg_addr == A_IRQ) && reg_wdata[1];

    p_count_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_count <= CNT_W'(DEPTH));

    p_ovf_saturate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_count == {OVF_W{1'b1}}) |=> (ovf_count == {OVF_W{1'b1}}));

    p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_re |=> $stable(reg_rdata));

    generate
        if (MODE == EGTS_AUTO) begin : g_auto
            p_self_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
                (!hold_valid && (fifo_count != '0)) |=> hold_valid);

            p_locked_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
                (hold_valid && !win_wr) |=> (hold_valid && $stable(held_entry)));

            p_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
                (hold_valid && win_wr) |=> !hold_valid);

            p_push_sets_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (ts_push && (fifo_count != CNT_W'(DEPTH))) |=> irq);

            p_irq_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (irq && !ack_wr) |=> irq);
        end else begin : g_legacy
            p_no_self_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
                (!hold_valid && !reg_we) |=> !hold_valid);

            p_level_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
                (ts_push && (fifo_count != CNT_W'(DEPTH))) |=> irq);
        end
    endgenerate
endmodule

bind egts_hold_fifo egts_hold_fifo_chk #(.MODE(MODE), .DEPTH(DEPTH), .OVF_W(OVF_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ts_push    (ts_push),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_we     (reg_we),
    .reg_re     (reg_re),
    .reg_rdata  (reg_rdata),
    .irq        (irq),
    .hold_valid (hold_valid),
    .fifo_count (fifo_count),
    .held_entry (held_entry),
    .ovf_count  (ovf_count)
);

// File: tb/egts_hold_fifo_tb.sv
`timescale 1ns/1ps
module egts_hold_fifo_tb;
    import egts_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  dom = '0;
    logic [29:0] ns = '0;
    logic [4:0]  sec = '0;
    logic [2:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic        push_s [2];
    logic        we_s   [2];
    logic        re_s   [2];
    logic [15:0] rdata_s [2];
    logic        irq_s  [2];
    int          checks = 0;
    int          fails  = 0;

    always #5 clk = ~clk;

    // index 0: auto mode, index 1: legacy mode
    egts_hold_fifo #(.MODE(EGTS_AUTO)) u_dut (
        .clk(clk), .rst_n(rst_n), .ts_push(push_s[0]), .ts_domain(dom), .ts_ns(ns),
        .ts_sec(sec), .reg_addr(addr), .reg_wdata(wdata), .reg_we(we_s[0]),
        .reg_re(re_s[0]), .reg_rdata(rdata_s[0]), .irq(irq_s[0]));

    egts_hold_fifo #(.MODE(EGTS_LEGACY)) u_dut_legacy (
        .clk(clk), .rst_n(rst_n), .ts_push(push_s[1]), .ts_domain(dom), .ts_ns(ns),
        .ts_sec(sec), .reg_addr(addr), .reg_wdata(wdata), .reg_we(we_s[1]),
        .reg_re(re_s[1]), .reg_rdata(rdata_s[1]), .irq(irq_s[1]));

    task automatic chk(string req, string what, logic [15:0] got, logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, got, exp);
        end
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push_ts(int d, logic [7:0] dm, logic [29:0] n, logic [4:0] s);
        dom = dm; ns = n; sec = s; push_s[d] = 1'b1;
        @(negedge clk);
        push_s[d] = 1'b0;
    endtask

    task automatic wr(int d, logic [2:0] a, logic [15:0] v);
        addr = a; wdata = v; we_s[d] = 1'b1;
        @(negedge clk);
        we_s[d] = 1'b0;
    endtask

    task automatic rd(int d, logic [2:0] a, output logic [15:0] v);
        addr = a; re_s[d] = 1'b1;
        @(negedge clk);
        re_s[d] = 1'b0;
        v = rdata_s[d];
    endtask

    task automatic t_reset();
        logic [15:0] v;
        chk("R1", "auto irq", {15'b0, irq_s[0]}, 16'h0000);
        chk("R1", "legacy irq", {15'b0, irq_s[1]}, 16'h0000);
        rd(0, A_WORD0, v); chk("R1", "word0", v, 16'h0000);
        rd(0, A_WORD3, v); chk("R1", "word3", v, 16'h0000);
        rd(0, A_OVF, v);   chk("R1", "overflow count", v, 16'h0000);
    endtask

    task automatic t_auto_load();
        logic [15:0] v;
        push_ts(0, 8'h5A, 30'h2345_6789, 5'h13);
        chk("R6", "irq after push", {15'b0, irq_s[0]}, 16'h0001);
        idle(1);
        rd(0, A_WORD0, v); chk("R2", "word0 A", v, 16'h5A07);
        rd(0, A_WORD1, v); chk("R2", "word1 A", v, 16'h6789);
        addr = A_WORD2; idle(1);
        chk("R11", "rdata held without re", rdata_s[0], 16'h6789);
        rd(0, A_WORD2, v); chk("R2", "word2 A", v, 16'h2345);
        rd(0, A_WORD3, v); chk("R2", "word3 A", v, 16'h0004);
    endtask

    task automatic t_lock();
        logic [15:0] v;
        push_ts(0, 8'h11, 30'h0000_00AA, 5'h01);
        push_ts(0, 8'h22, 30'h3FFF_FFFF, 5'h1F);
        idle(1);
        rd(0, A_WORD0, v); chk("R3", "word0 still A", v, 16'h5A07);
        rd(0, A_WORD3, v); chk("R3", "more flag set", v, 16'h8004);
    endtask

    task automatic t_irq_ack();
        logic [15:0] v;
        rd(0, A_IRQ, v); chk("R6", "irq status read", v, 16'h0002);
        wr(0, A_IRQ, 16'h0001);
        chk("R6", "irq after ack bit1=0", {15'b0, irq_s[0]}, 16'h0001);
        wr(0, A_IRQ, 16'h0002);
        chk("R6", "irq after ack", {15'b0, irq_s[0]}, 16'h0000);
        rd(0, A_IRQ, v); chk("R6", "irq status cleared", v, 16'h0000);
    endtask

    task automatic t_release_order();
        logic [15:0] v;
        wr(0, A_WORD1, 16'hFFFF);
        rd(0, A_WORD0, v); chk("R4", "valid clear after release", v, 16'h5A06);
        rd(0, A_WORD0, v); chk("R4", "word0 B loaded", v, 16'h1103);
        chk("R7", "irq on load with pending", {15'b0, irq_s[0]}, 16'h0001);
        rd(0, A_WORD3, v); chk("R3", "word3 B more", v, 16'h8000);
        wr(0, A_IRQ, 16'h0002);
        wr(0, A_WORD3, 16'h0000);
        idle(1);
        rd(0, A_WORD0, v); chk("R4", "word0 C loaded", v, 16'h2207);
        chk("R7", "no irq on last load", {15'b0, irq_s[0]}, 16'h0000);
        rd(0, A_WORD3, v); chk("R3", "word3 C no more", v, 16'h0007);
        rd(0, A_WORD1, v); chk("R2", "word1 C", v, 16'hFFFF);
        rd(0, A_WORD2, v); chk("R2", "word2 C", v, 16'h3FFF);
    endtask

    task automatic t_same_cycle();
        logic [15:0] v;
        dom = 8'h33; ns = 30'd5; sec = 5'd0;
        addr = A_WORD0; wdata = 16'h0000;
        push_s[0] = 1'b1; we_s[0] = 1'b1;
        @(negedge clk);
        push_s[0] = 1'b0; we_s[0] = 1'b0;
        idle(1);
        rd(0, A_WORD0, v); chk("R12", "push+release loads D", v, 16'h3301);
        rd(0, A_WORD1, v); chk("R12", "word1 D", v, 16'h0005);
    endtask

    task automatic t_overflow();
        logic [15:0] v;
        wr(0, A_WORD2, 16'h0000);
        idle(1);
        push_ts(0, 8'h40, 30'd0, 5'd0);
        idle(1);
        for (int k = 1; k <= 5; k++) push_ts(0, 8'(8'h40 + k), 30'(k), 5'd0);
        rd(0, A_OVF, v); chk("R10", "one drop counted", v, 16'h0001);
        for (int k = 1; k <= 4; k++) begin
            wr(0, A_WORD0, 16'h0000);
            idle(1);
            rd(0, A_WORD0, v);
            chk("R4", "drain order", v, {8'(8'h40 + k), 8'h01});
        end
        wr(0, A_WORD0, 16'h0000);
        idle(1);
        rd(0, A_WORD0, v); chk("R10", "dropped entry absent", {15'b0, v[0]}, 16'h0000);
    endtask

    task automatic t_saturate();
        logic [15:0] v;
        for (int k = 0; k < 5; k++) push_ts(0, 8'h50, 30'd0, 5'd0);
        push_s[0] = 1'b1;
        repeat (260) @(negedge clk);
        push_s[0] = 1'b0;
        rd(0, A_OVF, v); chk("R10", "overflow saturates", v, 16'h00FF);
    endtask

    task automatic t_legacy_ring();
        logic [15:0] v;
        push_ts(1, 8'h71, 30'd1, 5'd2);
        push_ts(1, 8'h72, 30'd2, 5'd3);
        idle(2);
        rd(1, A_WORD0, v); chk("R8", "no self load", v, 16'h0000);
        chk("R9", "irq while queued", {15'b0, irq_s[1]}, 16'h0001);
        wr(1, A_IRQ, 16'h0002);
        chk("R9", "ack has no effect", {15'b0, irq_s[1]}, 16'h0001);
        wr(1, A_RING, 16'h0001);
        rd(1, A_WORD0, v); chk("R8", "ring done loads L1", v, 16'h7105);
        chk("R9", "irq with L2 queued", {15'b0, irq_s[1]}, 16'h0001);
        wr(1, A_RING, 16'h0001);
        rd(1, A_WORD0, v); chk("R8", "ring done loads L2", v, 16'h7207);
        chk("R9", "irq low when empty", {15'b0, irq_s[1]}, 16'h0000);
        wr(1, A_RING, 16'h0001);
        rd(1, A_WORD0, v); chk("R8", "ring done on empty clears valid", v, 16'h7206);
    endtask

    task automatic t_legacy_manual();
        logic [15:0] v;
        push_ts(1, 8'h73, 30'd3, 5'd0);
        idle(1);
        rd(1, A_WORD0, v); chk("R8", "still not loaded", v, 16'h7206);
        wr(1, A_WORD3, 16'h0001);
        rd(1, A_WORD0, v); chk("R5", "manual move loads L3", v, 16'h7301);
        push_ts(1, 8'h74, 30'd4, 5'd0);
        wr(1, A_WORD3, 16'h0001);
        rd(1, A_WORD0, v); chk("R5", "move while valid only releases", v, 16'h7300);
        wr(1, A_WORD3, 16'h0001);
        rd(1, A_WORD0, v); chk("R5", "manual move loads L4", v, 16'h7401);
        chk("R9", "irq low after last move", {15'b0, irq_s[1]}, 16'h0000);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        #2_000_000;
        checks++; fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < 2; i++) begin
            push_s[i] = 1'b0; we_s[i] = 1'b0; re_s[i] = 1'b0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_auto_load();
        t_lock();
        t_irq_ack();
        t_release_order();
        t_same_cycle();
        t_overflow();
        t_saturate();
        t_legacy_ring();
        t_legacy_manual();
        summary();
        $finish;
    end
endmodule